// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences the low-power state of a small 8-bit microcontroller core. When the core reports that it has executed its sleep instruction, the controller stops the oscillator driver, stalls the core, pulses a clear to the watchdog counter and updates two status flags. The first flag, the power-down bit, records that sleep was entered. The second flag, the timeout bit, records whether a watchdog expiry caused the wake.

Three kinds of event end sleep. A low level on the external reset pin raises a reset request. A watchdog expiry, when the watchdog is enabled, resumes the program. So does any interrupt request whose own enable bit is set. The global interrupt enable has no say in whether the device wakes. It only decides whether the core is told to branch to the interrupt vector once it has run the instruction it already fetched. In crystal oscillator modes the core stays stalled until a start-up delay has counted out. In RC mode that delay is skipped.

The wake inputs are asynchronous. They pass through a parameterised synchronizer before the state machine uses them.

Top module: `slp_wake_ctrl`

## Requirements
- R1: While `por_n` is low and just after it rises: `pd_bit`=1, `to_bit`=1, `osc_en`=1, `stall`=0, `wdt_clr`=0, `rst_req`=0, `vec_req`=0.
- R2: On the clock edge that samples `sleep_stb` high while running, the block does four things at once. It clears `pd_bit`, sets `to_bit`, drives `osc_en` low and drives `stall` high. In the same edge `wdt_clr` goes high for exactly one cycle.
- R3: `pd_bit` is set only by `por_n`. No wake of any kind sets it again.
- R4: A low on `ext_rst_n` shows on `rst_req` SYNC_STAGES+1 edges later and stays there while the pin is low. If the block is asleep, the same edge ends sleep with `osc_en`=1 and `stall`=0, and `pd_bit` and `to_bit` keep their values.
- R5: While asleep, `wdt_timeout` wakes the block and clears `to_bit` only when `wdt_en`=1. With `wdt_en`=0 the block stays asleep.
- R6: Bit i of `int_req` wakes the block only when bit i of `int_en` is 1. Bit 0 is the external edge, bit 1 is port change and bit 2 is EEPROM write done. `gie` has no effect on waking.
- R7: After an interrupt wake with `gie`=1, `vec_req` is high for exactly the one cycle in which `stall` first returns to 0. With `gie`=0, `vec_req` stays 0.
- R8: With `osc_rc`=0, `osc_en` returns on the wake edge and `stall` stays high for exactly STARTUP_CYCLES (default 1024) more edges. With `osc_rc`=1, `stall` drops on the wake edge itself.
- R9: If a wake condition is already present when `sleep_stb` is sampled, the R2 updates still happen, and the block wakes on the following edge.
- R10: When several wake causes arrive together, the reset pin beats the watchdog and the watchdog beats interrupts. A combined watchdog and interrupt wake clears `to_bit` and gives no `vec_req`.
- R11: `sleep_stb` is ignored during the start-up delay: no `wdt_clr`, and the release time does not change. While running, `wdt_timeout` leaves `to_bit` and `stall` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_stb | input | 1 | Core executed the sleep instruction (one cycle) |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog expiry, asynchronous |
| int_req | input | N_IRQ | Interrupt requests: 0 edge pin, 1 port change, 2 EEPROM done |
| int_en | input | N_IRQ | Individual interrupt enables |
| gie | input | 1 | Global interrupt enable |
| osc_rc | input | 1 | 1 = RC oscillator mode (no start-up delay) |
| osc_en | output | 1 | Oscillator driver enable |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Timeout status bit |
| stall | output | 1 | Hold the core |
| rst_req | output | 1 | Device reset request |
| vec_req | output | 1 | Branch to interrupt vector after the next instruction |

## Verification
The assertions assume three things about the inputs: `sleep_stb` arrives only from a running core, `por_n` is asserted from time zero, and the configuration inputs `wdt_en`, `int_en` and `osc_rc` are steady whenever a wake is being decided. The stimulus changes every input on the falling clock edge. It holds each asynchronous wake source for longer than the synchronizer depth, and it waits for the synchronizer to drain after clearing a source before the next sleep, so a stale request is never mistaken for a new one.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_WARM  = 2'd2
   } slp_state_e;
endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
   parameter int N_IRQ       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rst_n,
   input  logic             wdt_en,
   input  logic             wdt_timeout,
   input  logic [N_IRQ-1:0] int_req,
   input  logic [N_IRQ-1:0] int_en,
   output logic             pin_low,
   output logic             wdt_wake,
   output logic             int_wake
);
   localparam int W = N_IRQ + 2;

   logic [W-1:0] raw;
   logic [W-1:0] sy;

   assign raw = {wdt_timeout, ~ext_rst_n, int_req};

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad
         $error("SYNC_STAGES must be 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign sy = raw;
      end else begin : g_sync
         logic [W-1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign sy = stg[SYNC_STAGES-1];
      end
   endgenerate

   assign pin_low  = sy[N_IRQ];
   assign wdt_wake = sy[N_IRQ+1] & wdt_en;
   assign int_wake = |(sy[N_IRQ-1:0] & int_en);
endmodule

// File: rtl/slp_startup_timer.sv
module slp_startup_timer #(
   parameter int CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic done
);
   localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt;

   generate
      if (CYCLES < 2) begin : g_bad
         $error("CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (run)        cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
   end

   assign done = run && (cnt == LAST);

   // R8
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
   import slp_pkg::*;
#(
   parameter int N_IRQ          = 3,
   parameter int SYNC_STAGES    = 2,
   parameter int STARTUP_CYCLES = 1024
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sleep_stb,
   input  logic             ext_rst_n,
   input  logic             wdt_en,
   input  logic             wdt_timeout,
   input  logic [N_IRQ-1:0] int_req,
   input  logic [N_IRQ-1:0] int_en,
   input  logic             gie,
   input  logic             osc_rc,
   output logic             osc_en,
   output logic             wdt_clr,
   output logic             pd_bit,
   output logic             to_bit,
   output logic             stall,
   output logic             rst_req,
   output logic             vec_req
);
   generate
      if (N_IRQ < 1) begin : g_bad
         $error("N_IRQ must be at least 1");
      end
   endgenerate

   slp_state_e state, state_n;
   logic pd_q, pd_n, to_q, to_n;
   logic clr_q, clr_n, rst_q;
   logic vec_q, vec_n, pend_q, pend_n;
   logic tmr_clr, tmr_done;
   logic pin_low, wake_wdt, wake_int;

   slp_wake_detect #(.N_IRQ(N_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst_n(por_n), .ext_rst_n(ext_rst_n), .wdt_en(wdt_en),
      .wdt_timeout(wdt_timeout), .int_req(int_req), .int_en(int_en),
      .pin_low(pin_low), .wdt_wake(wake_wdt), .int_wake(wake_int));

   slp_startup_timer #(.CYCLES(STARTUP_CYCLES)) u_tmr (
      .clk(clk), .rst_n(por_n), .clr(tmr_clr),
      .run(state == ST_WARM), .done(tmr_done));

   always_comb begin
      logic resume, want_vec;
      state_n  = state;
      pd_n     = pd_q;
      to_n     = to_q;
      clr_n    = 1'b0;
      vec_n    = 1'b0;
      pend_n   = pend_q;
      tmr_clr  = 1'b0;
      resume   = 1'b0;
      want_vec = 1'b0;
      case (state)
         ST_RUN: begin
            if (sleep_stb) begin
               state_n = ST_SLEEP;
               pd_n    = 1'b0;
               to_n    = 1'b1;
               clr_n   = 1'b1;
               tmr_clr = 1'b1;
               pend_n  = 1'b0;
            end
         end
         ST_SLEEP: begin
            if (pin_low) begin
               state_n = ST_RUN;
               pend_n  = 1'b0;
            end else if (wake_wdt) begin
               to_n   = 1'b0;
               resume = 1'b1;
            end else if (wake_int) begin
               want_vec = gie;
               resume   = 1'b1;
            end
            if (resume) begin
               if (osc_rc) begin
                  state_n = ST_RUN;
                  vec_n   = want_vec;
                  pend_n  = 1'b0;
               end else begin
                  state_n = ST_WARM;
                  pend_n  = want_vec;
               end
            end
         end
         ST_WARM: begin
            if (pin_low) begin
               state_n = ST_RUN;
               pend_n  = 1'b0;
            end else if (tmr_done) begin
               state_n = ST_RUN;
               vec_n   = pend_q;
               pend_n  = 1'b0;
            end
         end
         default: state_n = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state  <= ST_RUN;
         pd_q   <= 1'b1;
         to_q   <= 1'b1;
         clr_q  <= 1'b0;
         rst_q  <= 1'b0;
         vec_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         state  <= state_n;
         pd_q   <= pd_n;
         to_q   <= to_n;
         clr_q  <= clr_n;
         rst_q  <= pin_low;
         vec_q  <= vec_n;
         pend_q <= pend_n;
      end
   end

   assign osc_en  = (state != ST_SLEEP);
   assign stall   = (state != ST_RUN);
   assign wdt_clr = clr_q;
   assign pd_bit  = pd_q;
   assign to_bit  = to_q;
   assign rst_req = rst_q;
   assign vec_req = vec_q;

   // R3
   pd_no_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      !$rose(pd_bit));
   // R5
   to_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(to_bit) |-> $past(wake_wdt));
   // R2
   entry_flags_chk: assert property (@(posedge clk) disable iff (!por_n)
      wdt_clr |-> (!pd_bit && to_bit && stall));
   // R2
   clr_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
      wdt_clr |=> !wdt_clr);
   // R7
   vec_release_chk: assert property (@(posedge clk) disable iff (!por_n)
      vec_req |-> (!stall && $past(stall)));
   // R8
   osc_stall_chk: assert property (@(posedge clk) disable iff (!por_n)
      !osc_en |-> stall);
endmodule

// File: tb/slp_wake_ctrl_test.sv
module slp_wake_ctrl_test;
   localparam int L  = 2;
   localparam int SC = 1024;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sleep_stb = 1'b0, ext_rst_n = 1'b1, wdt_en = 1'b0, wdt_timeout = 1'b0;
   logic [2:0] int_req = '0, int_en = '0;
   logic gie = 1'b0, osc_rc = 1'b1;
   logic osc_en, wdt_clr, pd_bit, to_bit, stall, rst_req, vec_req;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   slp_wake_ctrl #(.N_IRQ(3), .SYNC_STAGES(L), .STARTUP_CYCLES(SC)) uut (
      .clk(clk), .por_n(por_n), .sleep_stb(sleep_stb), .ext_rst_n(ext_rst_n),
      .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .int_req(int_req),
      .int_en(int_en), .gie(gie), .osc_rc(osc_rc), .osc_en(osc_en),
      .wdt_clr(wdt_clr), .pd_bit(pd_bit), .to_bit(to_bit), .stall(stall),
      .rst_req(rst_req), .vec_req(vec_req));

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic enter_sleep();
      sleep_stb = 1'b1;
      step(1);
      sleep_stb = 1'b0;
   endtask

   task automatic clear_sources();
      int_req = '0; int_en = '0; gie = 1'b0;
      wdt_timeout = 1'b0; wdt_en = 1'b0; ext_rst_n = 1'b1;
      step(L + 2);
   endtask

   task automatic t_reset();
      chk("R1", "pd", pd_bit, 1'b1);   chk("R1", "to", to_bit, 1'b1);
      chk("R1", "osc", osc_en, 1'b1);  chk("R1", "stall", stall, 1'b0);
      por_n = 1'b1;
      step(1);
      chk("R1", "clr", wdt_clr, 1'b0); chk("R1", "rst", rst_req, 1'b0);
      chk("R1", "vec", vec_req, 1'b0); chk("R1", "pd after", pd_bit, 1'b1);
   endtask

   task automatic t_entry();
      osc_rc = 1'b1;
      enter_sleep();
      chk("R2", "clr", wdt_clr, 1'b1); chk("R2", "pd", pd_bit, 1'b0);
      chk("R2", "to", to_bit, 1'b1);   chk("R2", "osc", osc_en, 1'b0);
      chk("R2", "stall", stall, 1'b1);
      step(1);
      chk("R2", "clr one cycle", wdt_clr, 1'b0);
      step(4);
      chk("R2", "still asleep", osc_en, 1'b0);
      int_en[0] = 1'b1; int_req[0] = 1'b1; gie = 1'b0;
      step(L);
      chk("R6", "not yet", osc_en, 1'b0);
      step(1);
      chk("R6", "woke osc", osc_en, 1'b1); chk("R8", "rc no delay", stall, 1'b0);
      chk("R7", "gie0 no vec", vec_req, 1'b0);
      chk("R3", "pd stays 0", pd_bit, 1'b0);
      clear_sources();
   endtask

   task automatic t_int_mask();
      enter_sleep();
      int_req = 3'b111; int_en = 3'b000; gie = 1'b1;
      step(L + 4);
      chk("R6", "masked stays asleep", stall, 1'b1);
      int_en = 3'b100;
      step(1);
      chk("R6", "enabled bit2 wakes", stall, 1'b0);
      chk("R7", "vec pulse", vec_req, 1'b1);
      step(1);
      chk("R7", "vec one cycle", vec_req, 1'b0);
      clear_sources();
   endtask

   task automatic t_wdt();
      enter_sleep();
      wdt_en = 1'b0; wdt_timeout = 1'b1;
      step(L + 4);
      chk("R5", "disabled wdt ignored", osc_en, 1'b0);
      chk("R5", "to kept", to_bit, 1'b1);
      wdt_en = 1'b1;
      step(1);
      chk("R5", "wdt wake", stall, 1'b0);
      chk("R5", "to cleared", to_bit, 1'b0);
      chk("R5", "no vec", vec_req, 1'b0);
      clear_sources();
   endtask

   task automatic t_pin();
      enter_sleep();
      ext_rst_n = 1'b0;
      step(L);
      chk("R4", "latency", rst_req, 1'b0);
      step(1);
      chk("R4", "rst_req", rst_req, 1'b1); chk("R4", "osc", osc_en, 1'b1);
      chk("R4", "stall", stall, 1'b0);     chk("R4", "pd kept", pd_bit, 1'b0);
      chk("R4", "to kept", to_bit, 1'b1);
      ext_rst_n = 1'b1;
      step(L);
      chk("R4", "held", rst_req, 1'b1);
      step(1);
      chk("R4", "released", rst_req, 1'b0);
      clear_sources();
   endtask

   task automatic t_crystal();
      osc_rc = 1'b0;
      enter_sleep();
      int_req[1] = 1'b1; int_en[1] = 1'b1; gie = 1'b1;
      step(L + 1);
      chk("R8", "osc back", osc_en, 1'b1);
      chk("R8", "still stalled", stall, 1'b1);
      step(10);
      sleep_stb = 1'b1;
      step(1);
      sleep_stb = 1'b0;
      chk("R11", "no clr in warm", wdt_clr, 1'b0);
      chk("R11", "osc kept", osc_en, 1'b1);
      step(SC - 12);
      chk("R8", "stall at last count", stall, 1'b1);
      chk("R7", "no early vec", vec_req, 1'b0);
      step(1);
      chk("R8", "released", stall, 1'b0);
      chk("R7", "vec after delay", vec_req, 1'b1);
      step(1);
      chk("R7", "vec ends", vec_req, 1'b0);
      clear_sources();
      osc_rc = 1'b1;
   endtask

   task automatic t_pending();
      int_req[2] = 1'b1; int_en[2] = 1'b1;
      step(L + 1);
      enter_sleep();
      chk("R9", "clr", wdt_clr, 1'b1); chk("R9", "pd", pd_bit, 1'b0);
      chk("R9", "to", to_bit, 1'b1);   chk("R9", "stall", stall, 1'b1);
      step(1);
      chk("R9", "woke next", stall, 1'b0);
      chk("R9", "osc", osc_en, 1'b1);
      clear_sources();
   endtask

   task automatic t_prio();
      enter_sleep();
      wdt_en = 1'b1; wdt_timeout = 1'b1;
      int_req[0] = 1'b1; int_en[0] = 1'b1; gie = 1'b1;
      step(L + 1);
      chk("R10", "woke", stall, 1'b0);
      chk("R10", "to cleared", to_bit, 1'b0);
      chk("R10", "no vec", vec_req, 1'b0);
      step(1);
      chk("R10", "no vec later", vec_req, 1'b0);
      clear_sources();
      enter_sleep();
      ext_rst_n = 1'b0; wdt_en = 1'b1; wdt_timeout = 1'b1;
      step(L + 1);
      chk("R10", "pin wins rst", rst_req, 1'b1);
      chk("R10", "pin wins to", to_bit, 1'b1);
      clear_sources();
   endtask

   task automatic t_run_ignore();
      wdt_en = 1'b1; wdt_timeout = 1'b1;
      step(L + 4);
      chk("R11", "to unchanged", to_bit, 1'b1);
      chk("R11", "no stall", stall, 1'b0);
      clear_sources();
   endtask

   initial begin
      step(3);
      t_reset();
      t_entry();
      t_int_mask();
      t_wdt();
      t_pin();
      t_crystal();
      t_pending();
      t_prio();
      t_run_ignore();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule